// File: doc/BRIEF.md
# FIFO Threshold DMA Request Logic

This block compares the occupancy of a receive FIFO and a transmit FIFO with two programmable thresholds. One comparison per direction drives both the DMA request line and the matching data interrupt request. The receive side requests service while the number of stored entries is strictly greater than its threshold. The transmit side requests service while the number of free entries is strictly smaller than its threshold. A request falls as soon as its comparison stops holding.

The block also supports fly-by transfers. In this mode a DMA acknowledge pin acts as a dedicated FIFO strobe, and no chip select is needed. Each acknowledge pin is active-low and passes through a synchronizer. When fly-by is enabled for that direction, each falling edge of the pin gives exactly one pop pulse to the receive FIFO or one push pulse to the transmit FIFO. A strobe that would read an empty receive FIFO is dropped, as is one that would write a full transmit FIFO, and an error pulse is raised in its place. The FIFOs and the DMA engine sit outside the block.

Top module: `fifo_dma_req_ctl`

## Requirements
- R1: `rx_dma_req_o` is high in the same cycle, combinationally, exactly when `rx_fill_i` is greater than `rx_thresh_i`, both compared as unsigned values.
- R2: `tx_dma_req_o` is high in the same cycle, combinationally, exactly when `tx_space_i` is less than `tx_thresh_i`, both compared as unsigned values.
- R3: `rx_data_irq_o` always equals the receive request condition of R1, and `tx_data_irq_o` always equals the transmit request condition of R2.
- R4: Fly-by receive is enabled when `flyby_cfg_i[0]` is 1. Suppose `rx_ack_n_i` is first sampled low at rising edge k after being sampled high at edge k-1, and suppose fly-by receive is enabled and `rx_fill_i` is nonzero at edge k+2. Then `rx_pop_o` is high for exactly the one cycle that follows edge k+2.
- R5: Fly-by transmit is enabled when `flyby_cfg_i[1]` is 1. Under the same timing as R4, a falling edge on `tx_ack_n_i` gives a one-cycle `tx_push_o` pulse after edge k+2, provided fly-by transmit is enabled and `tx_space_i` is nonzero at edge k+2.
- R6: If the enable bit of a direction is 0 at edge k+2, the falling edge of that direction's acknowledge pin produces neither a strobe nor an error pulse.
- R7: If fly-by is enabled at edge k+2 but the level is zero at that edge (`rx_fill_i` for receive, `tx_space_i` for transmit), no strobe is produced. Instead the direction's error output (`rx_flyby_err_o` or `tx_flyby_err_o`) is high for the cycle that follows edge k+2.
- R8: An acknowledge pin held low for any number of cycles gives exactly one strobe. A further strobe needs the pin to be sampled high on at least one rising edge and then low again.
- R9: While `rst_i` is high, every strobe and error output is low, and each acknowledge pin is treated as sampled high. As a result, a pin that is still low when reset is released counts as a fresh falling edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous reset, active high |
| rx_fill_i | input | CNT_W (6) | Entries stored in the receive FIFO |
| tx_space_i | input | CNT_W (6) | Free entries in the transmit FIFO |
| rx_thresh_i | input | TH_W (5) | Receive threshold |
| tx_thresh_i | input | TH_W (5) | Transmit threshold |
| flyby_cfg_i | input | 2 | Bit 0 enables fly-by receive, bit 1 enables fly-by transmit |
| rx_ack_n_i | input | 1 | Receive DMA acknowledge, active low, asynchronous |
| tx_ack_n_i | input | 1 | Transmit DMA acknowledge, active low, asynchronous |
| rx_dma_req_o | output | 1 | Receive DMA request |
| tx_dma_req_o | output | 1 | Transmit DMA request |
| rx_data_irq_o | output | 1 | Receive data interrupt request |
| tx_data_irq_o | output | 1 | Transmit data interrupt request |
| rx_pop_o | output | 1 | One-cycle pop strobe to the receive FIFO |
| tx_push_o | output | 1 | One-cycle push strobe to the transmit FIFO |
| rx_flyby_err_o | output | 1 | Pulse for a fly-by read of an empty receive FIFO |
| tx_flyby_err_o | output | 1 | Pulse for a fly-by write to a full transmit FIFO |

## Verification
The bench builds the block with its default values: a 32-entry depth, which gives 6-bit levels, 5-bit thresholds and a two-stage synchronizer. With these values the bench can sweep every level from 0 to 32 against thresholds at both ends of their range. This covers a level of exactly 32 against a threshold of 31, and a threshold of 0, which can never raise a transmit request. A two-stage synchronizer keeps the edge-to-strobe delay short, so the bench can hold acknowledges low for long stretches, keep one low across reset release, and make empty and full strobes within a few cycles of each other.

// File: rtl/fifo_dma_pkg.sv
package fifo_dma_pkg;

    // Default geometry of the attached FIFOs and threshold fields
    localparam int unsigned FIFO_DEPTH_DEF  = 32;
    localparam int unsigned TH_W_DEF        = 5;
    localparam int unsigned SYNC_STAGES_DEF = 2;

    // Directions handled by the block; the value is also the bit of the
    // fly-by configuration word that enables that direction
    typedef enum logic {
        DIR_RX = 1'b0,
        DIR_TX = 1'b1
    } dir_e;

    localparam int unsigned NUM_DIR = 2;

    // Per-direction result carried to the output ports
    typedef struct packed {
        logic req;     // threshold comparison holds
        logic strobe;  // fly-by pop (rx) or push (tx)
        logic err;     // fly-by strobe rejected
    } dir_status_t;

    // A fly-by access can proceed only with a nonzero level
    function automatic logic level_nonzero(input logic [31:0] lvl);
        return lvl != 32'd0;
    endfunction

endpackage

// File: rtl/ack_edge_sync.sv
module ack_edge_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk_i,
    input  logic rst_i,
    input  logic ack_n_i,
    output logic fall_o
);

    logic [STAGES-1:0] sync_q;
    logic              last_q;

    // Synchronizer chain; reset value 1 means "acknowledge idle"
    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            sync_q <= '1;
            last_q <= 1'b1;
        end else begin
            sync_q[0] <= ack_n_i;
            for (int i = 1; i < int'(STAGES); i++) begin
                sync_q[i] <= sync_q[i-1];
            end
            last_q <= sync_q[STAGES-1];
        end
    end

    // High for one cycle after the synchronized pin goes from 1 to 0
    assign fall_o = last_q & ~sync_q[STAGES-1];

endmodule

// File: rtl/level_cmp.sv
module level_cmp
    import fifo_dma_pkg::*;
#(
    parameter int unsigned CNT_W = 6,
    parameter int unsigned TH_W  = 5,
    parameter dir_e        DIR   = DIR_RX
) (
    input  logic [CNT_W-1:0] lvl_i,
    input  logic [TH_W-1:0]  th_i,
    output logic             hit_o
);

    logic [CNT_W-1:0] th_ext;
    assign th_ext = CNT_W'(th_i);

    generate
        if (DIR == DIR_RX) begin : g_above
            // Receive: stored entries strictly above threshold
            assign hit_o = lvl_i > th_ext;
        end else begin : g_below
            // Transmit: free entries strictly below threshold
            assign hit_o = lvl_i < th_ext;
        end
    endgenerate

endmodule

// File: rtl/flyby_gate.sv
module flyby_gate
    import fifo_dma_pkg::*;
#(
    parameter int unsigned CNT_W = 6
) (
    input  logic             clk_i,
    input  logic             rst_i,
    input  logic             fall_i,
    input  logic             en_i,
    input  logic [CNT_W-1:0] lvl_i,
    output logic             strobe_o,
    output logic             err_o
);

    logic take;
    logic room;

    assign take = fall_i & en_i;
    assign room = level_nonzero(32'(lvl_i));

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            strobe_o <= 1'b0;
            err_o    <= 1'b0;
        end else begin
            strobe_o <= take & room;
            err_o    <= take & ~room;
        end
    end

endmodule

// File: rtl/fifo_dma_req_ctl.sv
module fifo_dma_req_ctl
    import fifo_dma_pkg::*;
#(
    parameter int unsigned DEPTH       = FIFO_DEPTH_DEF,
    parameter int unsigned TH_W        = TH_W_DEF,
    parameter int unsigned SYNC_STAGES = SYNC_STAGES_DEF,
    localparam int unsigned CNT_W      = $clog2(DEPTH + 1)
) (
    input  logic               clk_i,
    input  logic               rst_i,
    input  logic [CNT_W-1:0]   rx_fill_i,
    input  logic [CNT_W-1:0]   tx_space_i,
    input  logic [TH_W-1:0]    rx_thresh_i,
    input  logic [TH_W-1:0]    tx_thresh_i,
    input  logic [NUM_DIR-1:0] flyby_cfg_i,
    input  logic               rx_ack_n_i,
    input  logic               tx_ack_n_i,
    output logic               rx_dma_req_o,
    output logic               tx_dma_req_o,
    output logic               rx_data_irq_o,
    output logic               tx_data_irq_o,
    output logic               rx_pop_o,
    output logic               tx_push_o,
    output logic               rx_flyby_err_o,
    output logic               tx_flyby_err_o
);

    logic [CNT_W-1:0] lvl    [NUM_DIR];
    logic [TH_W-1:0]  th     [NUM_DIR];
    logic             ack_n  [NUM_DIR];
    logic             fall   [NUM_DIR];
    logic             hit    [NUM_DIR];
    logic             stb    [NUM_DIR];
    logic             er     [NUM_DIR];
    dir_status_t      st     [NUM_DIR];

    assign lvl[DIR_RX]   = rx_fill_i;
    assign lvl[DIR_TX]   = tx_space_i;
    assign th[DIR_RX]    = rx_thresh_i;
    assign th[DIR_TX]    = tx_thresh_i;
    assign ack_n[DIR_RX] = rx_ack_n_i;
    assign ack_n[DIR_TX] = tx_ack_n_i;

    generate
        for (genvar d = 0; d < int'(NUM_DIR); d++) begin : g_dir
            localparam dir_e THIS_DIR = dir_e'(d);

            ack_edge_sync #(
                .STAGES (SYNC_STAGES)
            ) u_sync (
                .clk_i   (clk_i),
                .rst_i   (rst_i),
                .ack_n_i (ack_n[d]),
                .fall_o  (fall[d])
            );

            level_cmp #(
                .CNT_W (CNT_W),
                .TH_W  (TH_W),
                .DIR   (THIS_DIR)
            ) u_cmp (
                .lvl_i (lvl[d]),
                .th_i  (th[d]),
                .hit_o (hit[d])
            );

            flyby_gate #(
                .CNT_W (CNT_W)
            ) u_gate (
                .clk_i    (clk_i),
                .rst_i    (rst_i),
                .fall_i   (fall[d]),
                .en_i     (flyby_cfg_i[d]),
                .lvl_i    (lvl[d]),
                .strobe_o (stb[d]),
                .err_o    (er[d])
            );

            assign st[d] = '{req: hit[d], strobe: stb[d], err: er[d]};
        end
    endgenerate

    // One comparison feeds both the DMA request and the data interrupt
    assign rx_dma_req_o   = st[DIR_RX].req;
    assign rx_data_irq_o  = st[DIR_RX].req;
    assign tx_dma_req_o   = st[DIR_TX].req;
    assign tx_data_irq_o  = st[DIR_TX].req;
    assign rx_pop_o       = st[DIR_RX].strobe;
    assign tx_push_o      = st[DIR_TX].strobe;
    assign rx_flyby_err_o = st[DIR_RX].err;
    assign tx_flyby_err_o = st[DIR_TX].err;

endmodule

// File: rtl/fifo_dma_req_ctl_chk.sv
module fifo_dma_req_ctl_chk #(
    parameter int unsigned CNT_W = 6
) (
    input logic             clk_i,
    input logic             rst_i,
    input logic [CNT_W-1:0] rx_fill_i,
    input logic [CNT_W-1:0] tx_space_i,
    input logic [1:0]       flyby_cfg_i,
    input logic             rx_ack_n_i,
    input logic             tx_ack_n_i,
    input logic             rx_pop_o,
    input logic             tx_push_o,
    input logic             rx_flyby_err_o,
    input logic             tx_flyby_err_o
);

    // R4
    rx_pop_needs_data_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        rx_pop_o |-> $past(rx_fill_i) != '0);

    // R5
    tx_push_needs_room_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        tx_push_o |-> $past(tx_space_i) != '0);

    // R4
    rx_pop_follows_ack_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        rx_pop_o |-> $past(rx_ack_n_i, 3) == 1'b0);

    // R5
    tx_push_follows_ack_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        tx_push_o |-> $past(tx_ack_n_i, 3) == 1'b0);

    // R6
    rx_disabled_quiet_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        !$past(flyby_cfg_i[0]) |-> !rx_pop_o && !rx_flyby_err_o);

    // R6
    tx_disabled_quiet_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        !$past(flyby_cfg_i[1]) |-> !tx_push_o && !tx_flyby_err_o);

    // R7
    rx_err_on_empty_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        rx_flyby_err_o |-> $past(rx_fill_i) == '0 && !rx_pop_o);

    // R7
    tx_err_on_full_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        tx_flyby_err_o |-> $past(tx_space_i) == '0 && !tx_push_o);

    // R8
    rx_single_pulse_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        rx_pop_o |=> !rx_pop_o);

    // R8
    tx_single_pulse_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        tx_push_o |=> !tx_push_o);

endmodule

bind fifo_dma_req_ctl fifo_dma_req_ctl_chk #(
    .CNT_W (CNT_W)
) chk_i (
    .clk_i          (clk_i),
    .rst_i          (rst_i),
    .rx_fill_i      (rx_fill_i),
    .tx_space_i     (tx_space_i),
    .flyby_cfg_i    (flyby_cfg_i),
    .rx_ack_n_i     (rx_ack_n_i),
    .tx_ack_n_i     (tx_ack_n_i),
    .rx_pop_o       (rx_pop_o),
    .tx_push_o      (tx_push_o),
    .rx_flyby_err_o (rx_flyby_err_o),
    .tx_flyby_err_o (tx_flyby_err_o)
);

// File: tb/fifo_dma_req_ctl_tb_top.sv
`timescale 1ns/1ps
module fifo_dma_req_ctl_tb_top;

    localparam int CW = 6;
    localparam int TW = 5;
    localparam int WATCHDOG = 200000;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [CW-1:0] rx_fill = '0;
    logic [CW-1:0] tx_space = '0;
    logic [TW-1:0] rx_th = '0;
    logic [TW-1:0] tx_th = '0;
    logic [1:0]    cfg = 2'b00;
    logic          rx_ack_n = 1'b1;
    logic          tx_ack_n = 1'b1;
    logic rx_req, tx_req, rx_irq, tx_irq, rx_pop, tx_push, rx_err, tx_err;

    int total = 0;
    int fails = 0;
    int cycles = 0;
    bit done = 0;

    // reference model state
    int  hist_rx[$];
    int  hist_tx[$];
    bit  exp_pop, exp_push, exp_rerr, exp_terr;
    int  n_pop, n_push, n_rerr, n_terr;

    always #2.5 clk = ~clk;

    fifo_dma_req_ctl dut_i (
        .clk_i          (clk),
        .rst_i          (rst),
        .rx_fill_i      (rx_fill),
        .tx_space_i     (tx_space),
        .rx_thresh_i    (rx_th),
        .tx_thresh_i    (tx_th),
        .flyby_cfg_i    (cfg),
        .rx_ack_n_i     (rx_ack_n),
        .tx_ack_n_i     (tx_ack_n),
        .rx_dma_req_o   (rx_req),
        .tx_dma_req_o   (tx_req),
        .rx_data_irq_o  (rx_irq),
        .tx_data_irq_o  (tx_irq),
        .rx_pop_o       (rx_pop),
        .tx_push_o      (tx_push),
        .rx_flyby_err_o (rx_err),
        .tx_flyby_err_o (tx_err)
    );

    task automatic check(input string tag, input logic act, input logic exp);
        total++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %b expected %b at cycle %0d", tag, act, exp, cycles);
        end
    endtask

    task automatic check_n(input string tag, input int act, input int exp);
        total++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // Behavioural model: history of sampled acknowledge levels
    initial begin
        for (int i = 0; i < 4; i++) begin
            hist_rx.push_back(1);
            hist_tx.push_back(1);
        end
    end

    always @(posedge clk) begin
        int s;
        cycles++;
        hist_rx.push_back(rst ? 1 : int'(rx_ack_n));
        hist_tx.push_back(rst ? 1 : int'(tx_ack_n));
        if (hist_rx.size() > 8) void'(hist_rx.pop_front());
        if (hist_tx.size() > 8) void'(hist_tx.pop_front());
        s = hist_rx.size();
        if (rst) begin
            exp_pop = 0; exp_push = 0; exp_rerr = 0; exp_terr = 0;
        end else begin
            bit frx, ftx;
            frx = hist_rx[s-3] == 0 && hist_rx[s-4] == 1 && cfg[0];
            ftx = hist_tx[s-3] == 0 && hist_tx[s-4] == 1 && cfg[1];
            exp_pop  = frx && rx_fill != 0;
            exp_rerr = frx && rx_fill == 0;
            exp_push = ftx && tx_space != 0;
            exp_terr = ftx && tx_space == 0;
        end
    end

    // Per-cycle comparison, away from the active edge
    always @(negedge clk) begin
        if (!done) begin
            check("R1 rx request", rx_req, rx_fill > {1'b0, rx_th});
            check("R2 tx request", tx_req, tx_space < {1'b0, tx_th});
            check("R3 rx irq", rx_irq, rx_fill > {1'b0, rx_th});
            check("R3 tx irq", tx_irq, tx_space < {1'b0, tx_th});
            check("R4 rx pop", rx_pop, exp_pop);
            check("R5 tx push", tx_push, exp_push);
            check("R7 rx error", rx_err, exp_rerr);
            check("R7 tx error", tx_err, exp_terr);
            n_pop  += int'(rx_pop);
            n_push += int'(tx_push);
            n_rerr += int'(rx_err);
            n_terr += int'(tx_err);
        end
    end

    always @(posedge clk) begin
        if (cycles > WATCHDOG && !done) begin
            done = 1;
            fails++;
            total++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", total - fails, total);
            $finish;
        end
    end

    task automatic step(input int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            #1;
        end
    endtask

    task automatic clear_counts();
        n_pop = 0; n_push = 0; n_rerr = 0; n_terr = 0;
    endtask

    task automatic ack_both(input int low_cyc);
        rx_ack_n = 1'b0; tx_ack_n = 1'b0;
        step(low_cyc);
        rx_ack_n = 1'b1; tx_ack_n = 1'b1;
        step(3);
    endtask

    initial begin
        rx_ack_n = 1'b0;  // held low across reset release (R9)
        cfg = 2'b11;
        rx_fill = 6'd4;
        step(4);
        #1;
        check("R9 pop in reset", rx_pop, 1'b0);
        check("R9 error in reset", rx_err, 1'b0);
        clear_counts();
        rst = 1'b0;
        step(6);
        check_n("R9 low ack at reset release gives one pop", n_pop, 1);
        rx_ack_n = 1'b1;
        step(3);

        // R1 R2 R3: threshold sweeps
        foreach (rx_th[i]) ;
        for (int t = 0; t < 32; t += 31) begin
            rx_th = TW'(t); tx_th = TW'(t);
            for (int l = 0; l <= 32; l++) begin
                rx_fill = CW'(l); tx_space = CW'(l);
                step(1);
            end
        end
        rx_th = 5'd16; tx_th = 5'd8;
        for (int l = 32; l >= 0; l--) begin
            rx_fill = CW'(l); tx_space = CW'(32 - l);
            step(1);
        end

        // R4 R5: normal fly-by strobes
        rx_fill = 6'd10; tx_space = 6'd10; cfg = 2'b11;
        clear_counts();
        for (int k = 0; k < 3; k++) ack_both(2);
        check_n("R4 pops for three edges", n_pop, 3);
        check_n("R5 pushes for three edges", n_push, 3);

        // R8: long low gives one strobe; one high sample re-arms
        clear_counts();
        ack_both(12);
        check_n("R8 long rx low gives one pop", n_pop, 1);
        check_n("R8 long tx low gives one push", n_push, 1);
        clear_counts();
        rx_ack_n = 1'b0; step(3);
        rx_ack_n = 1'b1; step(1);
        rx_ack_n = 1'b0; step(3);
        rx_ack_n = 1'b1; step(4);
        check_n("R8 single high sample re-arms", n_pop, 2);

        // R6: disabled directions ignore acknowledges
        cfg = 2'b00;
        clear_counts();
        for (int k = 0; k < 3; k++) ack_both(2);
        check_n("R6 rx disabled no pop", n_pop, 0);
        check_n("R6 tx disabled no push", n_push, 0);
        check_n("R6 disabled no errors", n_rerr + n_terr, 0);
        cfg = 2'b10;
        clear_counts();
        ack_both(2);
        check_n("R6 only tx enabled rx quiet", n_pop + n_rerr, 0);
        check_n("R6 only tx enabled push", n_push, 1);

        // R7: empty receive, full transmit
        cfg = 2'b11; rx_fill = 6'd0; tx_space = 6'd0;
        clear_counts();
        ack_both(2);
        check_n("R7 empty rx no pop", n_pop, 0);
        check_n("R7 empty rx error", n_rerr, 1);
        check_n("R7 full tx no push", n_push, 0);
        check_n("R7 full tx error", n_terr, 1);
        rx_fill = 6'd32; tx_space = 6'd1;
        clear_counts();
        ack_both(2);
        check_n("R7 boundary levels strobe", n_pop + n_push, 2);
        check_n("R7 boundary levels no error", n_rerr + n_terr, 0);

        step(2);
        done = 1;
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

endmodule